// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks a pre-divider and a feedback divider for a phase-locked loop. The caller gives a reference frequency and a requested lane rate, both as whole MHz, and pulses `start`. The PLL target is twice the lane rate. The engine then walks the pre-divider values that keep the divided reference inside a fixed comparison window.

For each pre-divider it derives the feedback divider by integer division. Candidates whose feedback value falls outside the legal set are skipped. For each remaining candidate it computes the frequency that setting would really produce, and it keeps the setting with the smallest error. When the walk ends, `done` pulses for one cycle. The chosen pair, the achieved lane rate and a found flag then stay on the outputs until the next accepted start.

All divisions go through one shared shift-and-subtract divider. The divider produces one quotient bit per cycle. Each candidate costs two divisions.

Top module: `pll_div_search`

## Requirements
- R1: The PLL target is 2 × `lane_mhz`, clamped to at most 5000.
- R2: Pre-dividers run upward from max(1, ceil(fin/40)) to min(floor(fin/5), 31), so fin/prediv stays within 5..40 MHz.
- R3: For each pre-divider, fbdiv = floor(target × prediv / fin). A candidate is skipped when fbdiv < 12, fbdiv = 15 or fbdiv > 511, so a reported fbdiv lies in 12..14 or 16..511.
- R4: The achieved frequency is floor(fbdiv × fin / prediv), and the error is |target − achieved|. The reported setting has the smallest error of all legal candidates.
- R5: The best setting is replaced only on a strictly smaller error, so on a tie the smallest pre-divider is kept.
- R6: When no candidate is legal (this includes every fin below 5), `found` is 0, `prediv` and `fbdiv` are 1, and `lane_out_mhz` is 0.
- R7: `lane_out_mhz` is floor(achieved / 2) and never exceeds 2500.
- R8: `busy` rises in the cycle after an accepted start. `done` is high for exactly one cycle at the end of a search. `busy` falls only in the cycle after `done`.
- R9: A `start` that arrives while `busy` is high is ignored. The search in progress and its result are unaffected.
- R10: After reset, `busy`, `done` and `found` are 0, `prediv` and `fbdiv` are 1, and `lane_out_mhz` is 0.
- R11: While idle, all result outputs keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; accepted only when idle |
| fin_mhz | input | 8 | Reference frequency in MHz |
| lane_mhz | input | 12 | Requested lane rate in MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a search ends |
| found | output | 1 | A legal setting was found |
| prediv | output | 5 | Chosen pre-divider |
| fbdiv | output | 9 | Chosen feedback divider |
| lane_out_mhz | output | 12 | Achieved lane rate in MHz |

## Verification
The length of a search depends on how many pre-dividers are in range, and each division takes nineteen cycles. For that reason the bench counts no fixed latency. It waits, at falling edges, for the cycle in which `done` is high, and compares the result outputs there against an arithmetic model. `busy` is sampled at the first falling edge after the start edge. The next falling edge must show `done` low and `busy` low. A few idle cycles later the results must still be unchanged.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int FIN_W    = 8,
  parameter int LANE_W   = 12,
  parameter int PREDIV_W = 5,
  parameter int FBDIV_W  = 9,
  parameter int FOUT_MAX = 5000,
  parameter int PFD_MIN  = 5,
  parameter int PFD_MAX  = 40,
  parameter int FB_MIN   = 12,
  parameter int FB_HOLE  = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [FIN_W-1:0]              fin_mhz,
  input  logic [LANE_W-1:0]             lane_mhz,
  output logic                          busy,
  output logic                          done,
  output logic                          found,
  output logic [PREDIV_W-1:0]           prediv,
  output logic [FBDIV_W-1:0]            fbdiv,
  output logic [$clog2(FOUT_MAX+1)-2:0] lane_out_mhz
);
  localparam int FOUT_W = $clog2(FOUT_MAX + 1);
  localparam int NUM_A  = FOUT_W + PREDIV_W;
  localparam int NUM_B  = FBDIV_W + FIN_W;
  localparam int NUM_W  = (NUM_A > NUM_B) ? NUM_A : NUM_B;
  localparam int DEN_W  = FIN_W;
  localparam int CNT_W  = $clog2(NUM_W + 1);
  localparam int PD_CAP = (1 << PREDIV_W) - 1;
  localparam int FB_MAX = (1 << FBDIV_W) - 1;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_CHK, S_FB, S_ACT, S_END} state_t;
  state_t state;

  logic [FIN_W-1:0]    fin_q, pd, hi;
  logic [FOUT_W-1:0]   fout_q, best_f, min_err;
  logic [FBDIV_W-1:0]  fb_cur, best_fb;
  logic [PREDIV_W-1:0] best_pd;
  logic                found_q;
  logic [NUM_W-1:0]    dq;
  logic [DEN_W-1:0]    dr, dden;
  logic [CNT_W-1:0]    dcnt;

  // R1: target = 2 * lane, clamped
  logic [LANE_W:0]  twice;
  logic [FOUT_W-1:0] fout_in;
  assign twice   = {lane_mhz, 1'b0};
  assign fout_in = (twice > (LANE_W+1)'(FOUT_MAX)) ? FOUT_W'(FOUT_MAX) : FOUT_W'(twice);

  // shared restoring divider, one quotient bit per cycle
  logic             is_div, div_done, ge;
  logic [DEN_W:0]   trial, diff;
  assign is_div   = (state == S_LO) || (state == S_HI) || (state == S_FB) || (state == S_ACT);
  assign div_done = (dcnt == '0);
  assign trial    = {dr, dq[NUM_W-1]};
  assign ge       = trial >= {1'b0, dden};
  assign diff     = trial - {1'b0, dden};

  // R2 window bounds, R3 legality, R4 error
  logic [FIN_W-1:0]  lo_val, hi_val;
  logic              fb_bad;
  logic [FOUT_W-1:0] act, err;
  assign lo_val = (dq == '0) ? FIN_W'(1) : dq[FIN_W-1:0];
  assign hi_val = (dq > NUM_W'(PD_CAP)) ? FIN_W'(PD_CAP) : dq[FIN_W-1:0];
  assign fb_bad = (dq < NUM_W'(FB_MIN)) || (dq == NUM_W'(FB_HOLE)) || (dq > NUM_W'(FB_MAX));
  assign act    = dq[FOUT_W-1:0];
  assign err    = (fout_q >= act) ? (fout_q - act) : (act - fout_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      fin_q   <= '0;
      fout_q  <= '0;
      pd      <= '0;
      hi      <= '0;
      fb_cur  <= '0;
      best_pd <= PREDIV_W'(1);
      best_fb <= FBDIV_W'(1);
      best_f  <= '0;
      min_err <= '1;
      found_q <= 1'b0;
      dq      <= '0;
      dr      <= '0;
      dden    <= '0;
      dcnt    <= '0;
    end else if (is_div && !div_done) begin
      dr   <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      dq   <= {dq[NUM_W-2:0], ge};
      dcnt <= dcnt - 1'b1;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          fin_q   <= fin_mhz;
          fout_q  <= fout_in;
          best_pd <= PREDIV_W'(1);
          best_fb <= FBDIV_W'(1);
          best_f  <= '0;
          min_err <= '1;
          found_q <= 1'b0;
          dq      <= NUM_W'(fin_mhz) + NUM_W'(PFD_MAX - 1);
          dr      <= '0;
          dden    <= DEN_W'(PFD_MAX);
          dcnt    <= CNT_W'(NUM_W);
          state   <= S_LO;
        end
        S_LO: begin
          pd    <= lo_val;
          dq    <= NUM_W'(fin_q);
          dr    <= '0;
          dden  <= DEN_W'(PFD_MIN);
          dcnt  <= CNT_W'(NUM_W);
          state <= S_HI;
        end
        S_HI: begin
          hi    <= hi_val;
          state <= S_CHK;
        end
        S_CHK: begin
          if (pd > hi) begin
            state <= S_END;
          end else begin
            dq    <= NUM_W'(fout_q) * NUM_W'(pd);
            dr    <= '0;
            dden  <= fin_q;
            dcnt  <= CNT_W'(NUM_W);
            state <= S_FB;
          end
        end
        S_FB: begin
          if (fb_bad) begin
            pd    <= pd + 1'b1;
            state <= S_CHK;
          end else begin
            fb_cur <= dq[FBDIV_W-1:0];
            dq     <= NUM_W'(dq[FBDIV_W-1:0]) * NUM_W'(fin_q);
            dr     <= '0;
            dden   <= pd;
            dcnt   <= CNT_W'(NUM_W);
            state  <= S_ACT;
          end
        end
        S_ACT: begin
          // R5: strict comparison keeps the earliest pre-divider on a tie
          if (err < min_err) begin
            best_pd <= pd[PREDIV_W-1:0];
            best_fb <= fb_cur;
            best_f  <= act;
            min_err <= err;
            found_q <= 1'b1;
          end
          pd    <= pd + 1'b1;
          state <= S_CHK;
        end
        S_END:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7, R8
  assign busy         = (state != S_IDLE);
  assign done         = (state == S_END);
  assign found        = found_q;
  assign prediv       = best_pd;
  assign fbdiv        = best_fb;
  assign lane_out_mhz = best_f[FOUT_W-1:1];
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int PREDIV_W = 5,
  parameter int FBDIV_W  = 9,
  parameter int OUT_W    = 12,
  parameter int FOUT_MAX = 5000,
  parameter int FB_MIN   = 12,
  parameter int FB_HOLE  = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                found,
  input logic [PREDIV_W-1:0] prediv,
  input logic [FBDIV_W-1:0]  fbdiv,
  input logic [OUT_W-1:0]    lane_out_mhz
);
  a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_ends_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy);

  a_r3_fbdiv_legal: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (fbdiv >= FBDIV_W'(FB_MIN)) && (fbdiv != FBDIV_W'(FB_HOLE)));

  a_r6_defaults_when_none: assert property (@(posedge clk) disable iff (!rst_n)
    !found && !busy |-> prediv == PREDIV_W'(1) && fbdiv == FBDIV_W'(1) && lane_out_mhz == '0);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) |-> $stable(prediv) && $stable(fbdiv) && $stable(lane_out_mhz) && $stable(found));

  a_r7_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lane_out_mhz <= OUT_W'(FOUT_MAX / 2));
endmodule

bind pll_div_search pll_div_search_chk #(
  .PREDIV_W(PREDIV_W), .FBDIV_W(FBDIV_W), .OUT_W(FOUT_W-1),
  .FOUT_MAX(FOUT_MAX), .FB_MIN(FB_MIN), .FB_HOLE(FB_HOLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .found(found), .prediv(prediv), .fbdiv(fbdiv), .lane_out_mhz(lane_out_mhz)
);

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  fin_mhz = '0;
  logic [11:0] lane_mhz = '0;
  logic        busy, done, found;
  logic [4:0]  prediv;
  logic [8:0]  fbdiv;
  logic [11:0] lane_out_mhz;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pll_div_search u_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start(start), .fin_mhz(fin_mhz), .lane_mhz(lane_mhz),
    .busy(busy), .done(done), .found(found), .prediv(prediv), .fbdiv(fbdiv),
    .lane_out_mhz(lane_out_mhz)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input int fin, input int lane, output int e_pd, output int e_fb,
                       output int e_lane, output int e_found);
    int fout, lo, hi, best, min_e;
    fout = 2 * lane;
    if (fout > 5000) fout = 5000;
    lo = (fin + 39) / 40;
    if (lo < 1) lo = 1;
    hi = fin / 5;
    if (hi > 31) hi = 31;
    e_pd = 1; e_fb = 1; best = 0; min_e = 1 << 30; e_found = 0;
    for (int p = lo; p <= hi; p++) begin
      int f, a, e;
      f = fout * p / fin;
      if (f < 12 || f == 15 || f > 511) continue;
      a = f * fin / p;
      e = (fout > a) ? fout - a : a - fout;
      if (e < min_e) begin
        min_e = e; e_pd = p; e_fb = f; best = a; e_found = 1;
      end
    end
    e_lane = best / 2;
  endtask

  task automatic run(input int fin, input int lane, input bit poke, input bit hold);
    int e_pd, e_fb, e_lane, e_found, t;
    model(fin, lane, e_pd, e_fb, e_lane, e_found);
    @(negedge clk);
    fin_mhz = 8'(fin); lane_mhz = 12'(lane); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      fin_mhz = 8'd200; lane_mhz = 12'd777; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R8 done seen", int'(done), 1);
    chk(int'(prediv) == e_pd, poke ? "R9 prediv after ignored start" : "R2 prediv", int'(prediv), e_pd);
    chk(int'(fbdiv) == e_fb, "R3 fbdiv", int'(fbdiv), e_fb);
    chk(int'(lane_out_mhz) == e_lane, "R4 R7 achieved lane rate", int'(lane_out_mhz), e_lane);
    chk(int'(found) == e_found, e_found ? "R4 found" : "R6 not found", int'(found), e_found);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(busy == 1'b0, "R8 busy cleared", int'(busy), 0);
    if (hold) begin
      fin_mhz = 8'd99; lane_mhz = 12'd1500;
      repeat (5) @(negedge clk);
      chk(int'(prediv) == e_pd && int'(fbdiv) == e_fb, "R11 prediv/fbdiv held",
          int'(prediv) * 1000 + int'(fbdiv), e_pd * 1000 + e_fb);
      chk(int'(lane_out_mhz) == e_lane, "R11 lane held", int'(lane_out_mhz), e_lane);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fins [12] = '{0, 3, 5, 12, 20, 24, 37, 64, 99, 128, 199, 255};
    int lanes[9]  = '{10, 80, 150, 300, 445, 1234, 2500, 2600, 4095};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0 && done == 1'b0, "R10 busy/done at reset", int'(busy) + int'(done), 0);
    chk(found == 1'b0, "R10 found at reset", int'(found), 0);
    chk(prediv == 5'd1 && fbdiv == 9'd1, "R10 dividers at reset", int'(prediv) * 1000 + int'(fbdiv), 1001);
    chk(lane_out_mhz == '0, "R10 lane at reset", int'(lane_out_mhz), 0);
    rst_n = 1'b1;

    // R5 tie: fin 20, lane 300 -> prediv 1 and 2 both exact, 1 kept
    run(20, 300, 1'b0, 1'b0);
    chk(prediv == 5'd1 && fbdiv == 9'd30, "R5 earliest tie kept", int'(prediv) * 1000 + int'(fbdiv), 1030);
    // R3 hole: fin 20, lane 150 -> fbdiv 15 skipped, prediv 2 fbdiv 30
    run(20, 150, 1'b0, 1'b0);
    chk(prediv == 5'd2 && fbdiv == 9'd30, "R3 hole skipped", int'(prediv) * 1000 + int'(fbdiv), 2030);
    // R1 clamp: fin 24, lane 3000 -> target 5000, prediv 1 fbdiv 208, lane 2496
    run(24, 3000, 1'b0, 1'b0);
    chk(lane_out_mhz == 12'd2496 && fbdiv == 9'd208, "R1 target clamp", int'(lane_out_mhz), 2496);
    // R6 none legal
    run(24, 10, 1'b0, 1'b1);
    chk(found == 1'b0 && prediv == 5'd1 && fbdiv == 9'd1, "R6 defaults", int'(found), 0);
    // R9 start while busy ignored
    run(128, 1000, 1'b1, 1'b1);
    // R2 R4 sweep
    foreach (fins[i]) foreach (lanes[j]) run(fins[i], lanes[j], 1'b0, (i + j) % 5 == 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule